// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It walks a radix page table that lives in memory and has four levels. A request carries the virtual address, the access kind (read or write) and the privilege (user or supervisor). It also carries the physical base of the top-level table. The walker fetches one 64-bit entry per level through a valid/ready read port and allows one read in flight at a time. At each level it checks the entry's present, writable and user-allowed bits. Each entry that passes supplies the base of the next table, and the entry at the deepest level supplies the page frame. The physical address is that frame joined with the 12-bit page offset.

The walk stops at the first entry that fails a check. The block then reports a fault, the level (0 to 3) where the walk stopped, and a cause code. It issues no read for any level deeper than the one that failed. A core's translation path uses the block after a translation cache miss. Filling tables and handling faults are left to software.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `memReqValid` are all low.
- R2: The table index for level n is taken from virtual address bits [47-9n : 39-9n], so level 0 uses 47:39 and level 3 uses 20:12. The read address is the table base plus the index times 8. Virtual address bits 63:48 have no effect on any read address or result.
- R3: The level-0 table base is `rootBase` with bits 11:0 forced to zero. `rootBase`, `vaddr`, `isWrite` and `isUser` are sampled only in the cycle a start is accepted, and later changes to them do not affect the walk.
- R4: For a passing entry at level 0, 1 or 2, the next table base is entry bits 51:12 followed by twelve zero bits. Entry bits 63:52 and 11:3 are ignored.
- R5: A walk with no fault makes exactly four reads. It ends with `done`, `fault` low, `faultCause` 0, and `physAddr` equal to {12'b0, level-3 entry bits 51:12, vaddr[11:0]}.
- R6: An entry with bit 0 (present) clear ends the walk with `fault` high, `faultLevel` set to that level and `faultCause` 2'b01. No deeper level is read.
- R7: A write access that meets an entry with bit 1 (writable) clear ends the walk with `faultCause` 2'b10 at that level. No deeper level is read.
- R8: A user access that meets an entry with bit 2 (user-allowed) clear ends the walk with `faultCause` 2'b11 at that level. When an entry breaks several rules, not-present wins over write-protect, and write-protect wins over privilege.
- R9: `startReq` is ignored while a walk is in progress.
- R10: A read request holds `memReqValid` high with a stable `memReqAddr` until `memReqReady` is seen. No new request is issued before the response to the previous one arrives.
- R11: `done` is high for exactly one cycle per walk, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 64 | Virtual address to translate |
| isWrite | input | 1 | Access is a write |
| isUser | input | 1 | Access is from user mode |
| rootBase | input | 64 | Physical base of the level-0 table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | 64 | Translated physical address (valid when no fault) |
| fault | output | 1 | Walk ended in a page fault |
| faultLevel | output | 2 | Level at which the walk stopped |
| faultCause | output | 2 | 0 none, 1 not present, 2 write-protect, 3 privilege |
| memReqValid | output | 1 | Table read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Physical address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Page table entry read back |

## Verification
The bench builds the walker with its default parameters: four levels of nine-bit indices and 40-bit frames. It sweeps every level against all eight permission patterns and all four combinations of access kind and privilege. This reaches every fault level, every cause and every priority case between causes, alongside walks with no fault. The table contents are a computed function of the entry address, so the bench can predict every read address and frame arithmetically. The entries carry junk in their ignored bits. The bench stalls some requests and scrambles the sampled inputs in mid-walk, which exposes the request-hold and sampling rules.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    CauseNone    = 2'd0,
    CauseAbsent  = 2'd1,
    CauseNoWrite = 2'd2,
    CauseNoUser  = 2'd3
  } causeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request, reset level to 0
    logic descend;  // adopt next-level base from the entry
    logic finish;   // record final result or fault
  } strobeT;

endpackage

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int LEVELS  = 4,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 40,
  parameter int PTE_W   = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    strobe,
  input  logic [VA_W-1:0]           startVa,
  input  logic                      startWrite,
  input  logic                      startUser,
  input  logic [VA_W-1:0]           startRoot,
  input  logic [PTE_W-1:0]          memRspData,
  output logic [VA_W-1:0]           memReqAddr,
  output causeT                     rspCause,
  output logic                      atLastLevel,
  output logic [VA_W-1:0]           physAddr,
  output logic                      fault,
  output logic [$clog2(LEVELS)-1:0] faultLevel,
  output causeT                     faultCause
);

  localparam int LVL_W       = $clog2(LEVELS);
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam int PAD_W       = VA_W - FRAME_W - OFF_W;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;

  logic [VA_W-1:0]  vaQ;
  logic             writeQ;
  logic             userQ;
  logic [VA_W-1:0]  baseQ;
  logic [LVL_W-1:0] levelQ;

  // Index fields, level 0 uppermost
  logic [IDX_W-1:0] idxOf [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxOf[g] = vaQ[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign memReqAddr  = baseQ + (VA_W'(idxOf[levelQ]) << ENTRY_SHIFT);
  assign atLastLevel = (levelQ == LVL_W'(LEVELS-1));

  logic [VA_W-1:0] nextBase;
  assign nextBase = {{PAD_W{1'b0}}, memRspData[OFF_W +: FRAME_W], {OFF_W{1'b0}}};

  always_comb begin
    if (!memRspData[BIT_PRESENT])               rspCause = CauseAbsent;
    else if (writeQ && !memRspData[BIT_WRITE])  rspCause = CauseNoWrite;
    else if (userQ && !memRspData[BIT_USER])    rspCause = CauseNoUser;
    else                                        rspCause = CauseNone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ        <= '0;
      writeQ     <= 1'b0;
      userQ      <= 1'b0;
      baseQ      <= '0;
      levelQ     <= '0;
      physAddr   <= '0;
      fault      <= 1'b0;
      faultLevel <= '0;
      faultCause <= CauseNone;
    end else begin
      if (strobe.capture) begin
        vaQ        <= startVa;
        writeQ     <= startWrite;
        userQ      <= startUser;
        baseQ      <= {startRoot[VA_W-1:OFF_W], {OFF_W{1'b0}}};
        levelQ     <= '0;
        physAddr   <= '0;
        fault      <= 1'b0;
        faultLevel <= '0;
        faultCause <= CauseNone;
      end
      if (strobe.descend) begin
        baseQ  <= nextBase;
        levelQ <= levelQ + 1'b1;
      end
      if (strobe.finish) begin
        fault      <= (rspCause != CauseNone);
        faultLevel <= levelQ;
        faultCause <= rspCause;
        physAddr   <= (rspCause != CauseNone) ? '0
                      : {nextBase[VA_W-1:OFF_W], vaQ[OFF_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   memReqReady,
  input  logic   memRspValid,
  input  causeT  rspCause,
  input  logic   atLastLevel,
  output strobeT strobe,
  output logic   busy,
  output logic   done,
  output logic   memReqValid
);

  typedef enum logic [1:0] {StIdle, StIssue, StAwait, StReport} stateT;
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      StIdle: if (startReq) begin
        strobe.capture = 1'b1;
        stateNext      = StIssue;
      end
      StIssue: if (memReqReady) stateNext = StAwait;
      StAwait: if (memRspValid) begin
        if (rspCause != CauseNone || atLastLevel) begin
          strobe.finish = 1'b1;
          stateNext     = StReport;
        end else begin
          strobe.descend = 1'b1;
          stateNext      = StIssue;
        end
      end
      StReport: stateNext = StIdle;
      default:  stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNext;
  end

  assign busy        = (state == StIssue) || (state == StAwait);
  assign done        = (state == StReport);
  assign memReqValid = (state == StIssue);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int LEVELS  = 4,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 40,
  parameter int PTE_W   = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic [VA_W-1:0]           vaddr,
  input  logic                      isWrite,
  input  logic                      isUser,
  input  logic [VA_W-1:0]           rootBase,
  output logic                      busy,
  output logic                      done,
  output logic [VA_W-1:0]           physAddr,
  output logic                      fault,
  output logic [$clog2(LEVELS)-1:0] faultLevel,
  output logic [1:0]                faultCause,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [VA_W-1:0]           memReqAddr,
  input  logic                      memRspValid,
  input  logic [PTE_W-1:0]          memRspData
);

  strobeT strobe;
  causeT  rspCause;
  causeT  causeQ;
  logic   atLastLevel;

  pt_walker_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspCause    (rspCause),
    .atLastLevel (atLastLevel),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done),
    .memReqValid (memReqValid)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .FRAME_W(FRAME_W), .PTE_W(PTE_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startVa     (vaddr),
    .startWrite  (isWrite),
    .startUser   (isUser),
    .startRoot   (rootBase),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .rspCause    (rspCause),
    .atLastLevel (atLastLevel),
    .physAddr    (physAddr),
    .fault       (fault),
    .faultLevel  (faultLevel),
    .faultCause  (causeQ)
  );

  assign faultCause = causeQ;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic [1:0]      faultCause,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [VA_W-1:0] memReqAddr
);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  a_r6_fault_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> faultCause != 2'd0);

  a_r5_clean_no_cause: assert property (@(posedge clk) disable iff (!rstN)
    done && !fault |-> faultCause == 2'd0);

endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .faultCause  (faultCause),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [63:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic        isUser = 1'b0;
  logic [63:0] rootBase = '0;
  logic        busy, done, fault, memReqValid;
  logic [63:0] physAddr, memReqAddr;
  logic [1:0]  faultLevel, faultCause;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;

  int testCnt = 0;
  int failCnt = 0;
  int cycles = 0;

  // Expected-walk context
  logic [63:0] curVa, curRoot;
  logic [2:0]  permLvl [4];
  int          readCnt = 0;
  int          stallPer = 0;
  int          stallLeft = 0;
  logic        pend = 1'b0;
  logic [63:0] pendAddr;
  int          pendLvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .vaddr(vaddr),
    .isWrite(isWrite), .isUser(isUser), .rootBase(rootBase),
    .busy(busy), .done(done), .physAddr(physAddr), .fault(fault),
    .faultLevel(faultLevel), .faultCause(faultCause),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] frameFn(input logic [63:0] a);
    logic [63:0] t;
    t = (a >> 3) * 64'd2654435761 + 64'h1234;
    return t[39:0];
  endfunction

  function automatic logic [8:0] idxFn(input logic [63:0] va, input int lvl);
    return 9'((va >> (39 - 9*lvl)) & 64'h1ff);
  endfunction

  function automatic logic [63:0] tblAddr(input logic [63:0] va,
                                          input logic [63:0] root, input int lvl);
    logic [63:0] base, a;
    base = root & ~64'hfff;
    for (int l = 0; l < lvl; l++) begin
      a    = base + 64'(idxFn(va, l)) * 8;
      base = {12'h0, frameFn(a), 12'h0};
    end
    return base + 64'(idxFn(va, lvl)) * 8;
  endfunction

  // Memory model: checks each request address (R2, R3, R4), optional stalls
  always @(negedge clk) begin
    if (memRspValid) memRspValid = 1'b0;
    if (pend && !memReqValid) begin
      memRspValid = 1'b1;
      memRspData  = {12'hABC, frameFn(pendAddr), 9'h15A, permLvl[pendLvl]};
      pend        = 1'b0;
    end else if (memReqValid && !pend) begin
      if (stallLeft > 0) begin
        memReqReady = 1'b0;
        stallLeft--;
      end else begin
        memReqReady = 1'b1;
        pend        = 1'b1;
        pendAddr    = memReqAddr;
        pendLvl     = readCnt & 3;
        chk(memReqAddr == tblAddr(curVa, curRoot, readCnt & 3),
            "R2/R3/R4 request address", memReqAddr, tblAddr(curVa, curRoot, readCnt & 3));
        readCnt++;
        stallLeft = stallPer;
      end
    end else begin
      memReqReady = 1'b0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic walk(input logic [63:0] va, input logic [63:0] root,
                      input logic wr, input logic usr, input logic doubleStart);
    int  expLvl, expCause, w;
    logic [63:0] expPa;
    expLvl = 3; expCause = 0;
    for (int l = 0; l < 4; l++) begin
      if (expCause == 0) begin
        if (!permLvl[l][0])              begin expCause = 1; expLvl = l; end
        else if (wr && !permLvl[l][1])   begin expCause = 2; expLvl = l; end
        else if (usr && !permLvl[l][2])  begin expCause = 3; expLvl = l; end
      end
    end
    expPa = {12'h0, frameFn(tblAddr(va, root, 3)), va[11:0]};
    curVa = va; curRoot = root; readCnt = 0;
    @(negedge clk);
    vaddr = va; rootBase = root; isWrite = wr; isUser = usr; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    // R3: scramble sampled inputs after acceptance
    vaddr = ~va; rootBase = root ^ 64'h0000_0F0F_0000_5000; isWrite = ~wr; isUser = ~usr;
    if (doubleStart) begin
      @(negedge clk);
      startReq = 1'b1;  // R9: must be ignored
      @(negedge clk);
      startReq = 1'b0;
    end
    w = 0;
    while (!done && w < 300) begin
      @(negedge clk);
      w++;
    end
    chk(done, "R11 done seen", 64'(done), 64'd1);
    chk(!busy, "R11 busy low with done", 64'(busy), 64'd0);
    chk(fault == (expCause != 0), "R6/R7/R8 fault flag", 64'(fault), 64'(expCause != 0));
    chk(faultCause == 2'(expCause), "R6/R7/R8 cause", 64'(faultCause), 64'(expCause));
    if (expCause != 0)
      chk(faultLevel == 2'(expLvl), "R6 fault level", 64'(faultLevel), 64'(expLvl));
    else
      chk(physAddr == expPa, "R5 physical address", physAddr, expPa);
    chk(readCnt == expLvl + 1, "R5/R6 read count", 64'(readCnt), 64'(expLvl + 1));
    @(negedge clk);
    chk(!done, "R11 single-cycle done", 64'(done), 64'd0);
    if (doubleStart)
      chk(!busy, "R9 no second walk", 64'(busy), 64'd0);
  endtask

  initial begin
    for (int l = 0; l < 4; l++) permLvl[l] = 3'b111;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !fault && !memReqValid, "R1 reset state",
        {60'h0, busy, done, fault, memReqValid}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep: faulting level x permission pattern x access kind/privilege
    for (int lv = 0; lv < 4; lv++) begin
      for (int p = 0; p < 8; p++) begin
        for (int m = 0; m < 4; m++) begin
          for (int l = 0; l < 4; l++) permLvl[l] = 3'b111;
          permLvl[lv] = 3'(p);
          stallPer = (p + m) % 3;
          walk({16'(lv * 16'h1357 + p), 48'(64'h0000_9ABC_DEF1_2345 * (lv*32 + p*4 + m + 1))},
               64'h0000_0004_FFFF_F123 + 64'((lv*8 + p) << 12),
               m[0], m[1], 1'b0);
        end
      end
    end

    // R2: upper 16 bits ignored
    for (int l = 0; l < 4; l++) permLvl[l] = 3'b111;
    stallPer = 0;
    begin
      logic [63:0] pa0;
      walk(64'h0000_0102_001F_FFA8, 64'h4FFF_F000, 1'b0, 1'b1, 1'b0);
      pa0 = physAddr;
      walk(64'hFFFF_0102_001F_FFA8, 64'h4FFF_F000, 1'b0, 1'b1, 1'b0);
      chk(physAddr == pa0, "R2 reserved bits ignored", physAddr, pa0);
    end

    // R9: start during a walk ignored
    stallPer = 2;
    walk(64'h0000_7FFF_FFFF_F000, 64'h1000, 1'b1, 1'b0, 1'b1);
    permLvl[2] = 3'b000;
    walk(64'h0000_0000_0000_0FFF, 64'h2000, 1'b1, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule